// File: doc/BRIEF.md
# ATM Cell Payload Descrambler and Header Filter

This block takes a byte stream that is already aligned to 53-byte ATM cells and sits between cell delineation and cell storage. The five header bytes go through untouched. The 48 information-field bytes pass through a self-synchronizing descrambler with a 43-bit lag, which software can switch off. The first four header bytes are compared against a programmable value under a programmable mask. Only the generic flow control, payload type and cell loss priority fields take part in this comparison. A cell that matches is removed from the stream.

Cells are handled store-and-forward. Each cell is written into one half of a two-cell buffer. Once its last byte is in and the filter decision is known, it is either released or discarded. A released cell leaves as 53 back-to-back bytes with a start-of-cell flag on the first byte. A running count of forwarded cells is kept. The input may carry idle cycles anywhere and may deliver at most one byte per clock.

Top module: `atm_payload_filter`

## Requirements
- R1: After synchronous reset `out_valid` is 0, `cell_count` is 0 and the descrambler history is all zeros. The first 43 payload bits after reset are therefore XORed with zero.
- R2: The header bytes, at cell positions 0 to 4, leave the block equal to the bytes that entered.
- R3: With `dscr_en` = 1, each payload bit is the received bit XORed with the payload bit received 43 bit times earlier. Bits are taken most significant first within each byte.
- R4: Only payload bytes advance the descrambler history. Header bytes and idle cycles leave it unchanged, so the history runs on from one cell's payload into the next cell's payload.
- R5: With `dscr_en` = 0, payload bytes leave unchanged, but the history still advances on them. `dscr_en` is sampled per byte.
- R6: The header word places byte 0 in bits 31:24 and byte 3 in bits 7:0. Only bits 31:28, 3:1 and 0 are compared. A cell is a match when `((header ^ filt_match) & filt_mask)` is zero on those bits. Mask bits outside them have no effect. With `filt_en` = 0 no cell matches. The filter settings are sampled at the cell's last byte.
- R7: A matching cell produces no output byte at all.
- R8: Every accepted cell leaves in arrival order as 53 bytes on consecutive cycles. `out_soc` is set on the first byte only.
- R9: `cell_count` rises by exactly one in the same cycle that the last byte of a forwarded cell is presented. Dropped cells do not count.
- R10: Bytes that arrive before the first `in_soc` since reset are ignored and do not touch the history. An `in_soc` in mid-cell abandons the partial cell, which yields no output, and restarts at position 0. The payload bytes already taken from the abandoned cell have advanced the history. After 53 bytes the next byte starts a new cell.
- R11: Idle input cycles, where `in_valid` is 0, between or inside cells change neither the data nor the order of the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_soc | input | 1 | Input byte is position 0 of a cell |
| in_data | input | 8 | Input byte |
| dscr_en | input | 1 | Enable payload descrambling |
| filt_en | input | 1 | Enable header drop filter |
| filt_match | input | 32 | Header value to compare against |
| filt_mask | input | 32 | Per-bit compare enable (only field bits used) |
| out_valid | output | 1 | Output byte present |
| out_soc | output | 1 | Output byte is first of a cell |
| out_data | output | 8 | Output byte |
| cell_count | output | CNT_W | Number of forwarded cells |

## Verification
The hardest state to reach from the ports is the descrambler history as it crosses cell boundaries. It must have skipped every header byte and idle cycle. It must also have absorbed the payload of cells that were later dropped or abandoned part-way. The bench keeps its own 43-bit model that advances only on accepted payload positions. It drives long runs of back-to-back cells with idle gaps, filter sweeps that drop some cells, descrambler off/on switches and an abandoned partial cell. Any slip in history bookkeeping then shows up as corrupted payload in every later cell.

// File: rtl/atm_dsc_pkg.sv
package atm_dsc_pkg;
  // Header bits that take part in the drop compare: GFC, PTI, CLP
  localparam logic [31:0] FILT_FIELDS = 32'hF000_000F;

  function automatic logic hdr_hit(input logic [31:0] hdr,
                                   input logic [31:0] match,
                                   input logic [31:0] mask);
    return ((hdr ^ match) & mask & FILT_FIELDS) == 32'h0;
  endfunction
endpackage

// File: rtl/atm_cell_track.sv
module atm_cell_track #(
  parameter int CELL_LEN = 53,
  localparam int POS_W = $clog2(CELL_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_soc,
  output logic             take,
  output logic [POS_W-1:0] pos
);
  logic             synced_q;
  logic [POS_W-1:0] pos_q;

  assign pos  = in_soc ? '0 : pos_q;
  assign take = in_valid && (in_soc || synced_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      synced_q <= 1'b0;
      pos_q    <= '0;
    end else if (take) begin
      synced_q <= 1'b1;
      pos_q    <= (pos == POS_W'(CELL_LEN - 1)) ? '0 : pos + POS_W'(1);
    end
  end
endmodule

// File: rtl/atm_x43_descrambler.sv
module atm_x43_descrambler #(
  parameter int LAG = 43,
  parameter int W   = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           en,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   dout,
  output logic [LAG-1:0] hist
);
  logic [LAG-1:0] hist_q;
  logic [LAG-1:0] hist_n;

  // MSB first; hist[0] is the newest bit, hist[LAG-1] the one LAG bits back
  always_comb begin
    hist_n = hist_q;
    dout   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      dout[i] = en ? (din[i] ^ hist_n[LAG-1]) : din[i];
      hist_n  = {hist_n[LAG-2:0], din[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       hist_q <= '0;
    else if (step) hist_q <= hist_n;
  end

  assign hist = hist_q;
endmodule

// File: rtl/atm_hdr_filter.sv
module atm_hdr_filter #(
  parameter int HDR_W = 32,
  parameter int POS_W = 6,
  localparam int NB = HDR_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [POS_W-1:0] idx,
  input  logic [7:0]       din,
  input  logic             en,
  input  logic [HDR_W-1:0] match,
  input  logic [HDR_W-1:0] mask,
  output logic             drop
);
  import atm_dsc_pkg::*;
  logic [HDR_W-1:0] hdr_q;

  always_ff @(posedge clk) begin
    if (rst) hdr_q <= '0;
    else if (cap) begin
      for (int k = 0; k < NB; k++)
        if (idx == POS_W'(k)) hdr_q[HDR_W-1-8*k -: 8] <= din;
    end
  end

  assign drop = en && hdr_hit(hdr_q, match, mask);
endmodule

// File: rtl/atm_cell_buffer.sv
module atm_cell_buffer #(
  parameter int CELL_LEN = 53,
  parameter int W        = 8,
  localparam int POS_W   = $clog2(CELL_LEN),
  localparam int DEPTH   = 2 * CELL_LEN,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [POS_W-1:0] wr_pos,
  input  logic [W-1:0]     wr_data,
  input  logic             commit,
  output logic             rd_valid,
  output logic             rd_first,
  output logic             rd_last,
  output logic [W-1:0]     rd_data,
  output logic [1:0]       bank_full,
  output logic             wr_bank
);
  localparam logic [POS_W-1:0] LAST = POS_W'(CELL_LEN - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [1:0]       full_q, full_n;
  logic             wbank_q, rd_act_q, rbank_q;
  logic [POS_W-1:0] rpos_q;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic             rd_end;

  assign wr_addr = AW'(wr_pos) + (wbank_q ? AW'(CELL_LEN) : AW'(0));
  assign rd_addr = AW'(rpos_q) + (rbank_q ? AW'(CELL_LEN) : AW'(0));
  assign rd_end  = rd_act_q && (rpos_q == LAST);

  // Plain storage, no reset, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en)    mem[wr_addr] <= wr_data;
    if (rd_act_q) rd_data      <= mem[rd_addr];
  end

  always_comb begin
    full_n = full_q;
    if (rd_end) full_n[rbank_q] = 1'b0;
    if (commit) full_n[wbank_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q   <= '0;
      wbank_q  <= 1'b0;
      rd_act_q <= 1'b0;
      rbank_q  <= 1'b0;
      rpos_q   <= '0;
      rd_valid <= 1'b0;
      rd_first <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      full_q   <= full_n;
      rd_valid <= rd_act_q;
      rd_first <= rd_act_q && (rpos_q == '0);
      rd_last  <= rd_end;
      if (commit) wbank_q <= ~wbank_q;
      if (rd_act_q) begin
        if (rd_end) begin
          rpos_q <= '0;
          if (full_q[~rbank_q]) rbank_q <= ~rbank_q;
          else                  rd_act_q <= 1'b0;
        end else begin
          rpos_q <= rpos_q + POS_W'(1);
        end
      end else if (|full_q) begin
        rd_act_q <= 1'b1;
        rbank_q  <= ~full_q[0];
        rpos_q   <= '0;
      end
    end
  end

  assign bank_full = full_q;
  assign wr_bank   = wbank_q;
endmodule

// File: rtl/atm_payload_filter.sv
module atm_payload_filter #(
  parameter int CELL_LEN = 53,
  parameter int HDR_LEN  = 5,
  parameter int SCR_LAG  = 43,
  parameter int HDR_W    = 32,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_soc,
  input  logic [7:0]       in_data,
  input  logic             dscr_en,
  input  logic             filt_en,
  input  logic [HDR_W-1:0] filt_match,
  input  logic [HDR_W-1:0] filt_mask,
  output logic             out_valid,
  output logic             out_soc,
  output logic [7:0]       out_data,
  output logic [CNT_W-1:0] cell_count
);
  localparam int POS_W = $clog2(CELL_LEN);
  localparam int CAP_N = HDR_W / 8;

  logic             take;
  logic [POS_W-1:0] pos;
  logic             is_pay, is_last, hdr_cap, pay_step, drop, commit;
  logic [7:0]       dsc_byte, store_byte;
  logic [SCR_LAG-1:0] dscr_hist;
  logic             rd_valid, rd_first, rd_last;
  logic [7:0]       rd_data;
  logic [1:0]       buf_full;
  logic             buf_wbank;

  atm_cell_track #(.CELL_LEN(CELL_LEN)) u_track (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_soc(in_soc),
    .take(take), .pos(pos)
  );

  assign is_pay   = pos >= POS_W'(HDR_LEN);
  assign is_last  = pos == POS_W'(CELL_LEN - 1);
  assign hdr_cap  = take && (pos < POS_W'(CAP_N));
  assign pay_step = take && is_pay;

  atm_x43_descrambler #(.LAG(SCR_LAG), .W(8)) u_dscr (
    .clk(clk), .rst(rst), .step(pay_step), .en(dscr_en),
    .din(in_data), .dout(dsc_byte), .hist(dscr_hist)
  );

  atm_hdr_filter #(.HDR_W(HDR_W), .POS_W(POS_W)) u_filt (
    .clk(clk), .rst(rst), .cap(hdr_cap), .idx(pos), .din(in_data),
    .en(filt_en), .match(filt_match), .mask(filt_mask), .drop(drop)
  );

  assign store_byte = is_pay ? dsc_byte : in_data;
  assign commit     = take && is_last && !drop;

  atm_cell_buffer #(.CELL_LEN(CELL_LEN), .W(8)) u_buf (
    .clk(clk), .rst(rst), .wr_en(take), .wr_pos(pos), .wr_data(store_byte),
    .commit(commit), .rd_valid(rd_valid), .rd_first(rd_first),
    .rd_last(rd_last), .rd_data(rd_data), .bank_full(buf_full),
    .wr_bank(buf_wbank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_soc    <= 1'b0;
      out_data   <= '0;
      cell_count <= '0;
    end else begin
      out_valid <= rd_valid;
      out_soc   <= rd_first;
      out_data  <= rd_valid ? rd_data : '0;
      if (rd_valid && rd_last) cell_count <= cell_count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/atm_payload_filter_chk.sv
module atm_payload_filter_chk #(
  parameter int CELL_LEN = 53,
  parameter int LAG      = 43,
  parameter int CNT_W    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             out_valid,
  input logic             out_soc,
  input logic [CNT_W-1:0] cell_count,
  input logic             pay_step,
  input logic [LAG-1:0]   hist,
  input logic             commit,
  input logic [1:0]       bank_full,
  input logic             wr_bank
);
  localparam int RW = $clog2(CELL_LEN + 1);
  logic          past_valid;
  logic [RW-1:0] run;

  always_ff @(posedge clk) past_valid <= 1'b1;

  always_ff @(posedge clk) begin
    if (rst)            run <= '0;
    else if (out_valid) run <= out_soc ? RW'(1) : run + RW'(1);
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    past_valid && $past(rst) && !rst |-> !out_valid && cell_count == '0);

  assert_hist_hold_R4: assert property (@(posedge clk) disable iff (rst)
    past_valid && !pay_step |=> $stable(hist));

  assert_soc_valid_R8: assert property (@(posedge clk) disable iff (rst)
    out_soc |-> out_valid);

  assert_cell_body_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_soc |-> run >= RW'(1) && run <= RW'(CELL_LEN - 1));

  assert_soc_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    out_soc |-> run == '0 || run == RW'(CELL_LEN));

  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    commit |-> !bank_full[wr_bank]);

  assert_count_last_R9: assert property (@(posedge clk) disable iff (rst)
    past_valid && cell_count != $past(cell_count) |->
      out_valid && !out_soc && run == RW'(CELL_LEN - 1) &&
      cell_count == $past(cell_count) + CNT_W'(1));
endmodule

bind atm_payload_filter atm_payload_filter_chk #(
  .CELL_LEN(CELL_LEN), .LAG(SCR_LAG), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_soc(out_soc),
  .cell_count(cell_count), .pay_step(pay_step), .hist(dscr_hist),
  .commit(commit), .bank_full(buf_full), .wr_bank(buf_wbank)
);

// File: tb/tb_atm_payload_filter.sv
module tb_atm_payload_filter;
  localparam int CLK_P = 10;
  localparam int CNT_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_soc = 1'b0;
  logic [7:0] in_data = '0;
  logic dscr_en = 1'b1, filt_en = 1'b0;
  logic [31:0] filt_match = '0, filt_mask = '0;
  logic out_valid, out_soc;
  logic [7:0] out_data;
  logic [CNT_W-1:0] cell_count;

  atm_payload_filter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_soc(in_soc),
    .in_data(in_data), .dscr_en(dscr_en), .filt_en(filt_en),
    .filt_match(filt_match), .filt_mask(filt_mask), .out_valid(out_valid),
    .out_soc(out_soc), .out_data(out_data), .cell_count(cell_count)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, failures = 0, exp_cells = 0;
  bit done = 0;
  logic [42:0] hm = '0;
  logic [7:0] exp_d[$];
  logic       exp_s[$];
  string      exp_t[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Output monitor: sampled at the falling edge
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      if (exp_d.size() == 0) begin
        check(0, "R7", "unexpected output byte", out_data, 0);
      end else begin
        logic [7:0] d; logic s; string t;
        d = exp_d.pop_front(); s = exp_s.pop_front(); t = exp_t.pop_front();
        check(out_data == d, t, "output byte", out_data, d);
        check(out_soc == s, "R8", "start-of-cell flag", out_soc, s);
      end
    end
  end

  task automatic drive(input logic [7:0] b, input logic s, input int gap);
    in_valid = 1'b1; in_soc = s; in_data = b;
    @(negedge clk);
    in_valid = 1'b0; in_soc = 1'b0;
    if (gap > 0) repeat ($urandom_range(gap, 0)) @(negedge clk);
  endtask

  // Requirement model of one payload byte (MSB first, 43-bit lag)
  task automatic model_pay(input logic [7:0] x, output logic [7:0] y);
    for (int i = 7; i >= 0; i--) begin
      y[i] = dscr_en ? (x[i] ^ hm[42]) : x[i];
      hm = {hm[41:0], x[i]};
    end
  endtask

  function automatic bit will_drop(input logic [31:0] hw);
    return filt_en && (((hw ^ filt_match) & filt_mask & 32'hF000_000F) == 0);
  endfunction

  task automatic send_cell(input logic [31:0] hw, input int gap);
    bit dr;
    logic [7:0] b, y;
    dr = will_drop(hw);
    for (int k = 0; k < 53; k++) begin
      if (k < 4) begin b = hw[31-8*k -: 8]; y = b; end
      else if (k == 4) begin b = 8'hA5; y = b; end
      else begin b = 8'($urandom); model_pay(b, y); end
      if (!dr) begin
        exp_d.push_back(y); exp_s.push_back(k == 0);
        exp_t.push_back(k < 5 ? "R2" : (dscr_en ? "R3" : "R5"));
      end
      drive(b, k == 0, gap);
    end
    if (!dr) exp_cells++;
  endtask

  task automatic drain(input string tag);
    repeat (160) @(negedge clk);
    check(exp_d.size() == 0, "R8", {"all bytes out after ", tag}, exp_d.size(), 0);
    check(cell_count == CNT_W'(exp_cells), "R9", {"cell count after ", tag},
          cell_count, exp_cells);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(cell_count == 0, "R1", "count after reset", cell_count, 0);

    // R10: stray bytes before first start, then an abandoned partial cell
    for (int k = 0; k < 10; k++) drive(8'($urandom), 1'b0, 0);
    begin
      logic [7:0] b, y;
      for (int k = 0; k < 20; k++) begin
        b = 8'($urandom);
        if (k >= 5) model_pay(b, y);
        drive(b, k == 0, 0);
      end
    end
    send_cell(32'h1234_5678, 0);
    drain("R10 restart");

    // R3 R4 R8: back-to-back cells, payload history across cells
    for (int c = 0; c < 6; c++) send_cell($urandom, 0);
    drain("back-to-back");

    // R11: idle gaps inside and between cells
    for (int c = 0; c < 4; c++) begin
      send_cell($urandom, 3);
      repeat (c) @(negedge clk);
    end
    drain("gaps");

    // R5: descrambler off, then back on (history kept running)
    dscr_en = 1'b0;
    for (int c = 0; c < 2; c++) send_cell($urandom, 0);
    dscr_en = 1'b1;
    for (int c = 0; c < 2; c++) send_cell($urandom, 1);
    drain("R5 toggle");

    // R6 R7: GFC sweep, non-field mask bits set, one match dropped
    filt_en = 1'b1; filt_match = 32'h5ABC_DEF0; filt_mask = 32'hFFFF_FFF0;
    for (int g = 0; g < 16; g++)
      send_cell({4'(g), 24'($urandom), 4'($urandom)}, 0);
    drain("GFC sweep");

    // R6 R7: PTI sweep, CLP sweep
    filt_match = 32'h0000_0006; filt_mask = 32'h0000_000E;
    for (int p = 0; p < 8; p++)
      send_cell({28'($urandom), 3'(p), 1'($urandom)}, 0);
    filt_match = 32'h0000_0001; filt_mask = 32'h0000_0001;
    for (int c = 0; c < 2; c++) send_cell({31'($urandom), 1'(c)}, 0);
    drain("PTI CLP sweep");

    // R6: combined mask, and filter disabled passes a matching header
    filt_match = 32'h3000_0005; filt_mask = 32'hF000_000F;
    send_cell(32'h3123_4565, 0);
    send_cell(32'h3123_4564, 0);
    filt_en = 1'b0;
    send_cell(32'h3123_4565, 0);
    drain("R6 disable");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule